// File: doc/BRIEF.md
# Capability Descriptor Table Walker

This block reads a capability descriptor table out of a word-organised nonvolatile store and turns it into ready-to-use configuration values. After a start pulse it fetches the number of function entries and then visits each entry in turn. For every entry it reads the function type and the byte address of that function's section, and takes the channel counts, timings and resolutions from that section.

From those fields it derives right-aligned max-data masks for the digital output, analog output and analog input functions. It also raises a flag when any timer-class function is listed. Results sit in output registers. `done` rises once the last entry has been handled.

The store is reached through a simple read port. `rd_req` pulses for one cycle with a byte address on `rd_addr`. The store answers some cycles later with one `rd_valid` cycle carrying the 16-bit word. Only one read is ever outstanding. Addresses are byte offsets, and the word at offset A is the one the store holds at word index A/2.

Top module: `desc_walker`

## Requirements
- R1: When idle, a `start` pulse clears every result output and `done`, raises `busy`, and the first read issued is at byte offset 10.
- R2: The entry count is bits [7:0] of the word at offset 10. Entry i (counting from 0) takes its type from bits [5:0] of the word at 12+4i and its section address from the word at 14+4i. Entries are visited in ascending order. A count of 0 ends the walk with no further reads.
- R3: Type code 0 (digital input): `di_chans` is the word at section+6.
- R4: Type code 1 (digital output): `do_chans` is the word at section+6. `do_mask` holds that many ones, right-aligned; a count of 0 gives 0 and a count of 32 or more gives all ones.
- R5: Type code 3 (analog output): `ao_chans` is bits [13:4] of the word at section+10. With r equal to bits [15:8] of the word at section+16, `ao_mask` is 0x0FFF shifted right by 16−r for r ≤ 16 (r = 0 gives 0), and 0xFFFF for r > 16.
- R6: Type code 2 (analog input): `ai_chans` is bits [13:4] of the word at section+10. `ai_acq_ns` is the word at section+16 times 1000, and `ai_dly_ns` is the word at section+30 times 1000.
- R7: For type code 2, let g be bits [7:0] of the word at section+72. The header offset h is 74 when g = 0, and 74+2g+10·(1+⌊g/16⌋) otherwise. With r equal to bits [4:0] of the word at section+h+2, `ai_mask` is 0xFFFF shifted right by 16−r for r ≤ 16, and 0xFFFF for r > 16.
- R8: Type codes 4, 5 and 10 set `has_timer` and read nothing beyond the entry words. Any other unlisted code reads nothing more and changes no output.
- R9: After the last entry, `done` rises and `busy` falls in the same cycle. `rd_req` is never high in two consecutive cycles. Each entry costs exactly 2 reads, plus 1 for types 0 and 1, 2 for type 3, and 5 for type 2.
- R10: A `start` pulse while `busy` is high is ignored. While idle with no `start`, every result output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk when idle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Last walk completed |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid for one cycle |
| rd_data | input | 16 | Word returned by the store |
| di_chans | output | 16 | Digital input channel count |
| do_chans | output | 16 | Digital output channel count |
| do_mask | output | 32 | Digital output max-data mask |
| ai_chans | output | 10 | Analog input channel count |
| ai_mask | output | 16 | Analog input max-data mask |
| ai_acq_ns | output | 32 | Minimum acquisition time in ns |
| ai_dly_ns | output | 32 | Minimum delay time in ns |
| ao_chans | output | 10 | Analog output channel count |
| ao_mask | output | 16 | Analog output max-data mask |
| has_timer | output | 1 | A timer-class function was listed |

## Verification
A corrupted entry index or section register makes the walk read the wrong words. That shows at the end of the walk as a wrong total read count or as result fields that disagree with the table. A wrong dispatch on the type code either leaves a result at zero or adds reads that the per-type read budget does not allow. Errors in the gain-table offset or the mask saturation appear only in the analog input and output masks. Directed tables therefore place gain counts and resolutions at 0, 16, above 16 and 255, and randomised tables mix all type codes under varying read latency.

// File: rtl/desc_walker.sv
module desc_walker #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [15:0]   rd_data,
  output logic [15:0]   di_chans,
  output logic [15:0]   do_chans,
  output logic [31:0]   do_mask,
  output logic [9:0]    ai_chans,
  output logic [15:0]   ai_mask,
  output logic [31:0]   ai_acq_ns,
  output logic [31:0]   ai_dly_ns,
  output logic [9:0]    ao_chans,
  output logic [15:0]   ao_mask,
  output logic          has_timer
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  typedef enum logic [3:0] {
    OP_CNT, OP_TYPE, OP_SEC, OP_DI_N, OP_DO_N, OP_AO_N, OP_AO_R,
    OP_AI_N, OP_AI_ACQ, OP_AI_DLY, OP_AI_G, OP_AI_R
  } op_t;

  st_t          st;
  op_t          op;
  logic [7:0]   cnt, idx;
  logic [5:0]   ftype;
  logic [AW-1:0] sec, hoff;

  assign busy   = (st != S_IDLE);
  assign rd_req = (st == S_REQ);

  always_comb begin
    case (op)
      OP_CNT:    rd_addr = AW'(10);
      OP_TYPE:   rd_addr = AW'(12 + 4 * int'(idx));
      OP_SEC:    rd_addr = AW'(14 + 4 * int'(idx));
      OP_DI_N,
      OP_DO_N:   rd_addr = sec + AW'(6);
      OP_AO_N,
      OP_AI_N:   rd_addr = sec + AW'(10);
      OP_AO_R,
      OP_AI_ACQ: rd_addr = sec + AW'(16);
      OP_AI_DLY: rd_addr = sec + AW'(30);
      OP_AI_G:   rd_addr = sec + AW'(72);
      OP_AI_R:   rd_addr = sec + hoff + AW'(2);
      default:   rd_addr = '0;
    endcase
  end

  logic       got;
  logic       known;
  logic       entry_end;
  logic       last;
  logic [7:0] ao_r;
  logic [4:0] ai_r;
  logic [7:0] gn;

  assign got       = (st == S_WAIT) && rd_valid;
  assign known     = (ftype <= 6'd3);
  assign entry_end = got && ((op == OP_SEC && !known) || op == OP_DI_N ||
                             op == OP_DO_N || op == OP_AO_R || op == OP_AI_R);
  assign last      = ({1'b0, idx} + 9'd1) >= {1'b0, cnt};
  assign ao_r      = rd_data[15:8];
  assign ai_r      = rd_data[4:0];
  assign gn        = rd_data[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_CNT; cnt <= '0; idx <= '0; ftype <= '0;
      sec <= '0; hoff <= '0; done <= 1'b0; has_timer <= 1'b0;
      di_chans <= '0; do_chans <= '0; do_mask <= '0; ai_chans <= '0;
      ai_mask <= '0; ai_acq_ns <= '0; ai_dly_ns <= '0; ao_chans <= '0;
      ao_mask <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_REQ; op <= OP_CNT; done <= 1'b0; has_timer <= 1'b0;
          di_chans <= '0; do_chans <= '0; do_mask <= '0; ai_chans <= '0;
          ai_mask <= '0; ai_acq_ns <= '0; ai_dly_ns <= '0; ao_chans <= '0;
          ao_mask <= '0;
        end
        S_REQ: st <= S_WAIT;
        default: if (rd_valid) begin
          st <= S_REQ;
          case (op)
            OP_CNT: begin
              cnt <= rd_data[7:0]; idx <= '0; op <= OP_TYPE;
              if (rd_data[7:0] == 8'd0) begin st <= S_IDLE; done <= 1'b1; end
            end
            OP_TYPE: begin ftype <= rd_data[5:0]; op <= OP_SEC; end
            OP_SEC: begin
              sec <= AW'(rd_data);
              case (ftype)
                6'd0: op <= OP_DI_N;
                6'd1: op <= OP_DO_N;
                6'd2: op <= OP_AI_N;
                6'd3: op <= OP_AO_N;
                6'd4, 6'd5, 6'd10: has_timer <= 1'b1;
                default: ;
              endcase
            end
            OP_DI_N: di_chans <= rd_data;
            OP_DO_N: begin
              do_chans <= rd_data;
              do_mask  <= (rd_data >= 16'd32) ? '1 : ~(32'hFFFF_FFFF << rd_data[4:0]);
            end
            OP_AO_N: begin ao_chans <= rd_data[13:4]; op <= OP_AO_R; end
            OP_AO_R: ao_mask <= (ao_r > 8'd16) ? 16'hFFFF
                                 : (16'h0FFF >> (5'd16 - ao_r[4:0]));
            OP_AI_N: begin ai_chans <= rd_data[9+4:4]; op <= OP_AI_ACQ; end
            OP_AI_ACQ: begin ai_acq_ns <= 32'(rd_data) * 32'd1000; op <= OP_AI_DLY; end
            OP_AI_DLY: begin ai_dly_ns <= 32'(rd_data) * 32'd1000; op <= OP_AI_G; end
            OP_AI_G: begin
              hoff <= (gn == 8'd0) ? AW'(74)
                      : AW'(74 + 2 * int'(gn) + 10 * (1 + int'(gn >> 4)));
              op <= OP_AI_R;
            end
            OP_AI_R: ai_mask <= (ai_r > 5'd16) ? 16'hFFFF
                                 : (16'hFFFF >> (5'd16 - ai_r));
            default: ;
          endcase
          if (entry_end) begin
            if (last) begin st <= S_IDLE; done <= 1'b1; end
            else begin idx <= idx + 8'd1; op <= OP_TYPE; end
          end
        end
      endcase
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done && rd_req && rd_addr == AW'(10)));
  p_single_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_do_mask_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((do_mask & (do_mask + 32'd1)) == 32'd0));
  p_a_mask_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((ao_mask & (ao_mask + 16'd1)) == 16'd0) && ((ai_mask & (ai_mask + 16'd1)) == 16'd0)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({do_mask, ao_mask, ai_mask, di_chans, has_timer, done}));
endmodule

// File: tb/desc_walker_tb_top.sv
module desc_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic busy, done, rd_req, has_timer;
  logic [15:0] rd_addr, di_chans, do_chans, ai_mask, ao_mask;
  logic [31:0] do_mask, ai_acq_ns, ai_dly_ns;
  logic [9:0] ai_chans, ao_chans;

  always #2.5 clk = ~clk;

  desc_walker #(.AW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .di_chans(di_chans), .do_chans(do_chans), .do_mask(do_mask),
    .ai_chans(ai_chans), .ai_mask(ai_mask), .ai_acq_ns(ai_acq_ns),
    .ai_dly_ns(ai_dly_ns), .ao_chans(ao_chans), .ao_mask(ao_mask),
    .has_timer(has_timer));

  logic [15:0] mem [0:4095];
  int checks = 0, errors = 0, nreads = 0;
  logic [15:0] first_addr;

  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        automatic logic [15:0] a = rd_addr;
        automatic int lat = $urandom_range(0, 3);
        if (nreads == 0) first_addr = a;
        nreads++;
        repeat (lat + 1) @(negedge clk);
        rd_data = mem[a[12:1]];
        rd_valid = 1'b1;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(int a);
    return mem[(a >> 1) & 4095];
  endfunction

  logic [15:0] e_di, e_do, e_aim, e_aom;
  logic [31:0] e_dom, e_acq, e_dly;
  logic [9:0]  e_aic, e_aoc;
  logic        e_tmr;
  int          e_reads;

  task automatic model();
    int n, s, r, g, h;
    e_di = 0; e_do = 0; e_aim = 0; e_aom = 0; e_dom = 0; e_acq = 0; e_dly = 0;
    e_aic = 0; e_aoc = 0; e_tmr = 0; e_reads = 1;
    n = rd(10) & 8'hFF;
    for (int i = 0; i < n; i++) begin
      automatic int t = rd(12 + 4 * i) & 6'h3F;
      s = rd(14 + 4 * i);
      e_reads += 2;
      if (t == 0) begin e_di = rd(s + 6); e_reads += 1; end
      else if (t == 1) begin
        e_do = rd(s + 6); e_reads += 1;
        e_dom = (e_do >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << e_do) - 1);
      end else if (t == 3) begin
        e_aoc = rd(s + 10) >> 4; r = rd(s + 16) >> 8; e_reads += 2;
        e_aom = (r > 16) ? 16'hFFFF : 16'(16'h0FFF >> (16 - r));
      end else if (t == 2) begin
        e_aic = rd(s + 10) >> 4; e_acq = rd(s + 16) * 1000; e_dly = rd(s + 30) * 1000;
        g = rd(s + 72) & 8'hFF;
        h = (g == 0) ? 74 : 74 + 2 * g + 10 * (1 + g / 16);
        r = rd(s + h + 2) & 5'h1F; e_reads += 5;
        e_aim = (r > 16) ? 16'hFFFF : 16'(16'hFFFF >> (16 - r));
      end else if (t == 4 || t == 5 || t == 10) e_tmr = 1;
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 4096; i++) mem[i] = 16'($urandom);
  endtask

  task automatic entry(int i, int t, int s);
    mem[(12 + 4 * i) >> 1] = {10'($urandom), 6'(t)};
    mem[(14 + 4 * i) >> 1] = 16'(s);
  endtask

  task automatic run(string tag, bit restart);
    int cyc = 0;
    nreads = 0;
    model();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk({tag, " R9 done"}, done, 1);
    chk({tag, " R9 busy low"}, busy, 0);
    chk({tag, " R1 first addr"}, first_addr, 10);
    chk({tag, " R2 R9 R10 reads"}, nreads, e_reads);
    chk({tag, " R3 di"}, di_chans, e_di);
    chk({tag, " R4 do"}, {do_chans, do_mask}, {e_do, e_dom});
    chk({tag, " R5 ao"}, {ao_chans, ao_mask}, {e_aoc, e_aom});
    chk({tag, " R6 ai"}, {ai_chans, ai_acq_ns, ai_dly_ns}, {e_aic, e_acq, e_dly});
    chk({tag, " R7 ai mask"}, ai_mask, e_aim);
    chk({tag, " R8 timer"}, has_timer, e_tmr);
    repeat (4) @(negedge clk);
    chk({tag, " R10 hold"}, {do_mask, ao_mask, ai_mask, done}, {e_dom, e_aom, e_aim, 1'b1});
  endtask

  task automatic set_cnt(int n);
    mem[5] = {8'($urandom), 8'(n)};
  endtask

  initial begin
    void'($urandom(32'd715));
    fill();
    repeat (3) @(negedge clk);
    chk("R1 reset done", done, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset masks", {do_mask, ao_mask, ai_mask, has_timer}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    set_cnt(0); run("R2 empty", 0);
    set_cnt(2); entry(0, 1, 256); entry(1, 3, 1280);
    mem[(256 + 6) >> 1] = 0; mem[(1280 + 16) >> 1] = 16'h00AA; run("R4 R5 zero", 0);
    mem[(256 + 6) >> 1] = 40; mem[(1280 + 16) >> 1] = 16'h1400; run("R4 R5 sat", 0);
    mem[(256 + 6) >> 1] = 32; mem[(1280 + 16) >> 1] = 16'h1000; run("R4 R5 edge", 0);
    set_cnt(1); entry(0, 2, 512);
    for (int g = 0; g < 4; g++) begin
      automatic int gv = (g == 0) ? 0 : (g == 1) ? 16 : (g == 2) ? 255 : 15;
      mem[(512 + 72) >> 1] = {8'hA5, 8'(gv)};
      run("R7 gain", 0);
    end
    set_cnt(4); entry(0, 7, 256); entry(1, 63, 512); entry(2, 0, 768); entry(3, 10, 1024);
    run("R8 unknown", 0);
    set_cnt(2); entry(0, 5, 256); entry(1, 2, 2048); run("R10 restart", 1);
    for (int k = 0; k < 24; k++) begin
      automatic int n = $urandom_range(0, 6);
      fill(); set_cnt(n);
      for (int i = 0; i < n; i++) begin
        automatic int pick = $urandom_range(0, 9);
        automatic int t = (pick < 4) ? pick : (pick == 4) ? 4 : (pick == 5) ? 5
                          : (pick == 6) ? 10 : (pick == 7) ? 9 : 2;
        automatic int s = 256 + i * 1024;
        entry(i, t, s);
        mem[(s + 6) >> 1] = 16'($urandom_range(0, 40));
        if (t == 3) mem[(s + 16) >> 1] = {8'($urandom_range(0, 20)), 8'($urandom)};
      end
      run("rand", k == 5);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule